// File: doc/BRIEF.md
# Vector Register Gather Unit

This block assembles a destination vector by picking elements out of a source vector. Each destination element takes the source element whose position is given by an index. The index can come per element from an index vector at the element width, per element from an index vector whose fields are always 16 bits wide, from one scalar register value, or from a small unsigned immediate. The last two apply one index to every element. Any index at or beyond the number of elements in the register (VLMAX = VLEN / SEW, with LMUL fixed at 1) produces zero. It never wraps.

The surrounding vector pipeline presents one request per handshake. A request carries the source vector, the index operands, the element width, the active length and start position, an optional per-element mask, the previous destination value and the tail policy. Elements outside the active body keep the previous value. Tail elements either keep it or become all ones. The result leaves a four-stage pipeline. If the consumer stalls, the whole pipeline holds and the input stops accepting.

Top module: `vgather_top`

## Requirements
- R1: With mode 0 (index vector at element width, read from the lower VLEN bits of `in_idx`), every active element i receives source element `idx[i]`.
- R2: With mode 1, index i is always read from bits [16i+15:16i] of `in_idx`, whatever the element width.
- R3: With mode 2, every active element receives the source element selected by the full XLEN-bit unsigned `in_scalar`.
- R4: With mode 3, every active element receives the source element selected by the 5-bit unsigned `in_uimm`.
- R5: In every mode, an index greater than or equal to VLMAX yields an all-zero element. All bits of the index count in this comparison.
- R6: `in_sew` encodes 0/1/2/3 as 8/16/32/64-bit elements, and VLMAX = VLEN / element width.
- R7: Elements at positions below `in_vstart` (and below `in_vl`) keep their `in_old` value.
- R8: When `in_mask_en` is 1, an element whose bit `in_mask[i]` is 0 keeps its `in_old` value. When `in_mask_en` is 0, the mask has no effect.
- R9: Elements at positions `in_vl` and above keep `in_old` when `in_tail_agn` is 0, and become all ones when it is 1.
- R10: A request accepted in cycle c (`in_valid` and `in_ready` high) appears with `out_valid` high in cycle c+4, provided `out_ready` stays high.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and `in_ready` is low.
- R12: During reset, and right after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high |
| in_mode | input | 2 | Index source: 0 vector, 1 16-bit vector, 2 scalar, 3 immediate |
| in_sew | input | 2 | Element width code (8/16/32/64) |
| in_vl | input | $clog2(VLEN/8+1) | Active length in elements |
| in_vstart | input | $clog2(VLEN/8+1) | First element to write |
| in_mask_en | input | 1 | Apply per-element mask |
| in_mask | input | VLEN/8 | Mask, bit i governs element i |
| in_tail_agn | input | 1 | Tail policy: 1 fill ones, 0 keep old |
| in_src | input | VLEN | Source vector |
| in_idx | input | 2*VLEN | Index vector (16-bit mode uses all bits) |
| in_scalar | input | XLEN | Scalar index |
| in_uimm | input | 5 | Immediate index |
| in_old | input | VLEN | Previous destination value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | VLEN | Destination vector |

## Verification
A wrong element selection or a wrong byte lane inside the crossbar shows up as a wrong byte in `out_data` in the cycle the request emerges, four cycles after acceptance. Each directed case is built so that every source byte is distinct, so a mis-steered lane cannot hide. A corrupted per-element disposition (body, kept or tail) shows the previous value, all ones or a gathered byte in the wrong place in that same output. A broken stall path shows within one cycle as changing data or a raised `in_ready` while the consumer holds off.

// File: rtl/vgather_pkg.sv
package vgather_pkg;

  typedef enum logic [1:0] {
    IDX_VEC    = 2'd0,
    IDX_VEC16  = 2'd1,
    IDX_SCALAR = 2'd2,
    IDX_IMM    = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    EL_KEEP = 2'd0,
    EL_PICK = 2'd1,
    EL_ONES = 2'd2
  } el_kind_e;

endpackage

// File: rtl/vgather_index.sv
// Per-element index extraction, range test and element disposition.
module vgather_index #(
  parameter int NELEM = 16,
  parameter int XLEN  = 64,
  parameter int IMMW  = 5,
  parameter int IXW   = 64,
  localparam int EIW  = $clog2(NELEM),
  localparam int VLW  = $clog2(NELEM + 1)
) (
  input  vgather_pkg::idx_mode_e               mode,
  input  logic [1:0]                           sew,
  input  logic [VLW-1:0]                       vl,
  input  logic [VLW-1:0]                       vstart,
  input  logic                                 mask_en,
  input  logic [NELEM-1:0]                     mask,
  input  logic                                 tail_agn,
  input  logic [16*NELEM-1:0]                  idx_grp,
  input  logic [XLEN-1:0]                      scalar,
  input  logic [IMMW-1:0]                      uimm,
  output logic [NELEM-1:0][EIW-1:0]            sel,
  output logic [NELEM-1:0]                     zero,
  output vgather_pkg::el_kind_e [NELEM-1:0]    kind
);

  logic [IXW-1:0] vlmax;
  assign vlmax = IXW'(NELEM >> sew);

  for (genvar i = 0; i < NELEM; i++) begin : g_el
    localparam logic [VLW-1:0] POS  = VLW'(i);
    localparam logic [IXW-1:0] POSX = IXW'(i);

    logic [IXW-1:0] f8, f16, f32, f64, fe16, raw;
    vgather_pkg::el_kind_e k_el;

    assign f8   = IXW'(idx_grp[i*8 +: 8]);
    assign fe16 = IXW'(idx_grp[i*16 +: 16]);

    if (i < NELEM / 2) begin : g_w16
      assign f16 = IXW'(idx_grp[i*16 +: 16]);
    end else begin : g_n16
      assign f16 = '0;
    end
    if (i < NELEM / 4) begin : g_w32
      assign f32 = IXW'(idx_grp[i*32 +: 32]);
    end else begin : g_n32
      assign f32 = '0;
    end
    if (i < NELEM / 8) begin : g_w64
      assign f64 = IXW'(idx_grp[i*64 +: 64]);
    end else begin : g_n64
      assign f64 = '0;
    end

    always_comb begin
      case (mode)
        vgather_pkg::IDX_VEC: begin
          case (sew)
            2'd0:    raw = f8;
            2'd1:    raw = f16;
            2'd2:    raw = f32;
            default: raw = f64;
          endcase
        end
        vgather_pkg::IDX_VEC16:  raw = fe16;
        vgather_pkg::IDX_SCALAR: raw = IXW'(scalar);
        default:                 raw = IXW'(uimm);
      endcase
    end

    always_comb begin
      if (POSX >= vlmax) begin
        k_el = vgather_pkg::EL_KEEP;
      end else if (POS >= vl) begin
        k_el = tail_agn ? vgather_pkg::EL_ONES : vgather_pkg::EL_KEEP;
      end else if ((POS < vstart) || (mask_en && !mask[i])) begin
        k_el = vgather_pkg::EL_KEEP;
      end else begin
        k_el = vgather_pkg::EL_PICK;
      end
    end

    assign zero[i] = (raw >= vlmax);
    assign sel[i]  = raw[EIW-1:0];
    assign kind[i] = k_el;
  end

endmodule

// File: rtl/vgather_xbar.sv
// Byte-granular crossbar: every destination byte chooses one source byte.
module vgather_xbar #(
  parameter int NELEM = 16,
  localparam int EIW  = $clog2(NELEM),
  localparam int VW   = 8 * NELEM
) (
  input  logic [1:0]                sew,
  input  logic [NELEM-1:0][EIW-1:0] sel,
  input  logic [NELEM-1:0]          zero,
  input  logic [VW-1:0]             src,
  output logic [VW-1:0]             gath
);

  for (genvar b = 0; b < NELEM; b++) begin : g_byte
    localparam logic [EIW-1:0] BI = EIW'(b);
    logic [EIW-1:0] eidx, boff, lane;
    logic [7:0]     pick;

    always_comb begin
      eidx = BI >> sew;
      boff = BI & EIW'((1 << sew) - 1);
      lane = EIW'(sel[eidx] << sew) | boff;
      pick = zero[eidx] ? 8'h00 : src[lane*8 +: 8];
    end

    assign gath[b*8 +: 8] = pick;
  end

endmodule

// File: rtl/vgather_merge.sv
// Applies body / prestart / mask / tail disposition per byte.
module vgather_merge #(
  parameter int NELEM = 16,
  localparam int EIW  = $clog2(NELEM),
  localparam int VW   = 8 * NELEM
) (
  input  logic [1:0]                        sew,
  input  vgather_pkg::el_kind_e [NELEM-1:0] kind,
  input  logic [VW-1:0]                     gath,
  input  logic [VW-1:0]                     old,
  output logic [VW-1:0]                     res
);

  for (genvar b = 0; b < NELEM; b++) begin : g_byte
    localparam logic [EIW-1:0] BI = EIW'(b);
    logic [EIW-1:0] eidx;
    logic [7:0]     val;

    always_comb begin
      eidx = BI >> sew;
      case (kind[eidx])
        vgather_pkg::EL_PICK: val = gath[b*8 +: 8];
        vgather_pkg::EL_ONES: val = 8'hFF;
        default:              val = old[b*8 +: 8];
      endcase
    end

    assign res[b*8 +: 8] = val;
  end

endmodule

// File: rtl/vgather_top.sv
// Four-stage gather pipeline: capture, index decode, crossbar, merge.
module vgather_top #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  parameter int IMMW = 5,
  localparam int NELEM = VLEN / 8,
  localparam int EIW   = $clog2(NELEM),
  localparam int VLW   = $clog2(NELEM + 1),
  localparam int IXW   = (XLEN > 64) ? XLEN : 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_mode,
  input  logic [1:0]          in_sew,
  input  logic [VLW-1:0]      in_vl,
  input  logic [VLW-1:0]      in_vstart,
  input  logic                in_mask_en,
  input  logic [NELEM-1:0]    in_mask,
  input  logic                in_tail_agn,
  input  logic [VLEN-1:0]     in_src,
  input  logic [2*VLEN-1:0]   in_idx,
  input  logic [XLEN-1:0]     in_scalar,
  input  logic [IMMW-1:0]     in_uimm,
  input  logic [VLEN-1:0]     in_old,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VLEN-1:0]     out_data
);

  // reset release synchroniser
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // stage valids
  logic s1_vld_q, s2_vld_q, s3_vld_q, s4_vld_q;
  logic s1_vld_d, s2_vld_d, s3_vld_d, s4_vld_d;
  logic adv;

  assign adv      = rst_sync_q && !(s4_vld_q && !out_ready);
  assign in_ready = adv;

  always_comb begin
    s1_vld_d = s1_vld_q;
    s2_vld_d = s2_vld_q;
    s3_vld_d = s3_vld_q;
    s4_vld_d = s4_vld_q;
    if (adv) begin
      s1_vld_d = in_valid;
      s2_vld_d = s1_vld_q;
      s3_vld_d = s2_vld_q;
      s4_vld_d = s3_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      s3_vld_q <= 1'b0;
      s4_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s2_vld_q <= s2_vld_d;
      s3_vld_q <= s3_vld_d;
      s4_vld_q <= s4_vld_d;
    end
  end

  logic en1, en2, en3, en4;
  assign en1 = adv && in_valid;
  assign en2 = adv && s1_vld_q;
  assign en3 = adv && s2_vld_q;
  assign en4 = adv && s3_vld_q;

  // stage 1: operand capture
  logic [1:0]        s1_mode_q, s1_sew_q;
  logic [VLW-1:0]    s1_vl_q, s1_vstart_q;
  logic              s1_men_q, s1_ta_q;
  logic [NELEM-1:0]  s1_mask_q;
  logic [VLEN-1:0]   s1_src_q, s1_old_q;
  logic [2*VLEN-1:0] s1_idx_q;
  logic [XLEN-1:0]   s1_scalar_q;
  logic [IMMW-1:0]   s1_uimm_q;

  always_ff @(posedge clk) begin
    if (en1) begin
      s1_mode_q   <= in_mode;
      s1_sew_q    <= in_sew;
      s1_vl_q     <= in_vl;
      s1_vstart_q <= in_vstart;
      s1_men_q    <= in_mask_en;
      s1_ta_q     <= in_tail_agn;
      s1_mask_q   <= in_mask;
      s1_src_q    <= in_src;
      s1_old_q    <= in_old;
      s1_idx_q    <= in_idx;
      s1_scalar_q <= in_scalar;
      s1_uimm_q   <= in_uimm;
    end
  end

  // stage 2: index decode
  logic [NELEM-1:0][EIW-1:0]         dec_sel;
  logic [NELEM-1:0]                  dec_zero;
  vgather_pkg::el_kind_e [NELEM-1:0] dec_kind;

  vgather_index #(
    .NELEM(NELEM), .XLEN(XLEN), .IMMW(IMMW), .IXW(IXW)
  ) u_index (
    .mode     (vgather_pkg::idx_mode_e'(s1_mode_q)),
    .sew      (s1_sew_q),
    .vl       (s1_vl_q),
    .vstart   (s1_vstart_q),
    .mask_en  (s1_men_q),
    .mask     (s1_mask_q),
    .tail_agn (s1_ta_q),
    .idx_grp  (s1_idx_q),
    .scalar   (s1_scalar_q),
    .uimm     (s1_uimm_q),
    .sel      (dec_sel),
    .zero     (dec_zero),
    .kind     (dec_kind)
  );

  logic [1:0]                        s2_sew_q;
  logic [NELEM-1:0][EIW-1:0]         s2_sel_q;
  logic [NELEM-1:0]                  s2_zero_q;
  vgather_pkg::el_kind_e [NELEM-1:0] s2_kind_q;
  logic [VLEN-1:0]                   s2_src_q, s2_old_q;

  always_ff @(posedge clk) begin
    if (en2) begin
      s2_sew_q  <= s1_sew_q;
      s2_sel_q  <= dec_sel;
      s2_zero_q <= dec_zero;
      s2_kind_q <= dec_kind;
      s2_src_q  <= s1_src_q;
      s2_old_q  <= s1_old_q;
    end
  end

  // stage 3: crossbar
  logic [VLEN-1:0] xb_gath;

  vgather_xbar #(.NELEM(NELEM)) u_xbar (
    .sew  (s2_sew_q),
    .sel  (s2_sel_q),
    .zero (s2_zero_q),
    .src  (s2_src_q),
    .gath (xb_gath)
  );

  logic [1:0]                        s3_sew_q;
  vgather_pkg::el_kind_e [NELEM-1:0] s3_kind_q;
  logic [VLEN-1:0]                   s3_gath_q, s3_old_q;

  always_ff @(posedge clk) begin
    if (en3) begin
      s3_sew_q  <= s2_sew_q;
      s3_kind_q <= s2_kind_q;
      s3_gath_q <= xb_gath;
      s3_old_q  <= s2_old_q;
    end
  end

  // stage 4: merge and output register
  logic [VLEN-1:0] mg_res, s4_data_q;

  vgather_merge #(.NELEM(NELEM)) u_merge (
    .sew  (s3_sew_q),
    .kind (s3_kind_q),
    .gath (s3_gath_q),
    .old  (s3_old_q),
    .res  (mg_res)
  );

  always_ff @(posedge clk) begin
    if (en4) begin
      s4_data_q <= mg_res;
    end
  end

  assign out_valid = s4_vld_q;
  assign out_data  = s4_data_q;

endmodule

// File: rtl/vgather_chk.sv
module vgather_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_data
);

  logic [2:0] occ_q;
  logic       acc, dlv;
  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= 3'd0;
    else        occ_q <= occ_q + 3'(acc) - 3'(dlv);
  end

  p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 3'd4);

  p_no_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ_q != 3'd0));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready ##1 out_ready ##1 out_ready |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r12: assert (!out_valid);
    end
  end

endmodule

bind vgather_top vgather_chk #(.VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/vgather_top_test.sv
`timescale 1ns/1ps
module vgather_top_test;

  localparam int VLEN = 128;
  localparam int XLEN = 64;
  localparam int NB   = VLEN / 8;
  localparam int VLW  = $clog2(NB + 1);

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid, in_ready;
  logic [1:0]          in_mode, in_sew;
  logic [VLW-1:0]      in_vl, in_vstart;
  logic                in_mask_en, in_tail_agn;
  logic [NB-1:0]       in_mask;
  logic [VLEN-1:0]     in_src, in_old;
  logic [2*VLEN-1:0]   in_idx;
  logic [XLEN-1:0]     in_scalar;
  logic [4:0]          in_uimm;
  logic                out_valid, out_ready;
  logic [VLEN-1:0]     out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  vgather_top #(.VLEN(VLEN), .XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_sew(in_sew), .in_vl(in_vl), .in_vstart(in_vstart),
    .in_mask_en(in_mask_en), .in_mask(in_mask), .in_tail_agn(in_tail_agn),
    .in_src(in_src), .in_idx(in_idx), .in_scalar(in_scalar), .in_uimm(in_uimm),
    .in_old(in_old), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [VLEN-1:0] pat(input logic [7:0] seed);
    logic [VLEN-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = 8'(b * 17) ^ seed;
    return r;
  endfunction

  function automatic logic [2*VLEN-1:0] put(input logic [2*VLEN-1:0] v, input int i,
                                            input int wb, input longint unsigned val);
    for (int k = 0; k < wb; k++) v[(i*wb + k)*8 +: 8] = val[k*8 +: 8];
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model(
      input int mode, input int sew, input int vl, input int vstart,
      input logic [NB-1:0] mask, input bit men, input bit ta,
      input logic [VLEN-1:0] src, input logic [2*VLEN-1:0] idx,
      input longint unsigned scalar, input int imm, input logic [VLEN-1:0] old);
    logic [VLEN-1:0] r;
    int eb, ne;
    eb = 1 << sew;
    ne = NB / eb;
    r  = old;
    for (int i = 0; i < ne; i++) begin
      longint unsigned ix;
      ix = 0;
      case (mode)
        0: for (int k = 0; k < eb; k++) ix |= 64'(idx[(i*eb + k)*8 +: 8]) << (8*k);
        1: ix = 64'(idx[i*16 +: 16]);
        2: ix = scalar;
        default: ix = 64'(imm);
      endcase
      for (int k = 0; k < eb; k++) begin
        if (i >= vl) begin
          if (ta) r[(i*eb + k)*8 +: 8] = 8'hFF;
        end else if (i >= vstart && (!men || mask[i])) begin
          if (ix >= 64'(ne)) r[(i*eb + k)*8 +: 8] = 8'h00;
          else begin
            int j;
            j = int'(ix);
            r[(i*eb + k)*8 +: 8] = src[(j*eb + k)*8 +: 8];
          end
        end
      end
    end
    return r;
  endfunction

  task automatic chk_v(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_i(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input string tag, input int mode, input int sew, input int vl,
                       input int vstart, input logic [NB-1:0] mask, input bit men,
                       input bit ta, input logic [VLEN-1:0] src,
                       input logic [2*VLEN-1:0] idx, input longint unsigned scalar,
                       input int imm, input logic [VLEN-1:0] old);
    logic [VLEN-1:0] exp;
    int cnt;
    exp = model(mode, sew, vl, vstart, mask, men, ta, src, idx, scalar, imm, old);
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'(mode); in_sew = 2'(sew);
    in_vl = VLW'(vl); in_vstart = VLW'(vstart); in_mask = mask;
    in_mask_en = men; in_tail_agn = ta; in_src = src; in_idx = idx;
    in_scalar = scalar; in_uimm = 5'(imm); in_old = old; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 0;
    while (!out_valid && cnt < 12) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    chk_i({tag, " R10 edges after accept"}, cnt, 3);
    chk_v({tag, " data"}, out_data, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_mode = '0; in_sew = '0; in_vl = '0; in_vstart = '0; in_mask = '0;
    in_mask_en = 1'b0; in_tail_agn = 1'b0; in_src = '0; in_idx = '0;
    in_scalar = '0; in_uimm = '0; in_old = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_i("R12 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_i("R12 out_valid after reset", int'(out_valid), 0);
    chk_i("R12 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_vec();
    logic [2*VLEN-1:0] ix;
    ix = '0;
    for (int i = 0; i < 16; i++) ix = put(ix, i, 1, 64'((i*5 + 3) % 16));
    do_op("R1 R6 vec sew8", 0, 0, 16, 0, '1, 0, 0, pat(8'h3C), ix, 0, 0, pat(8'hC5));
    ix = '0;
    ix = put(ix, 0, 4, 2); ix = put(ix, 1, 4, 4); ix = put(ix, 2, 4, 0); ix = put(ix, 3, 4, 200);
    do_op("R1 R5 R6 vec sew32", 0, 2, 4, 0, '1, 0, 0, pat(8'h11), ix, 0, 0, pat(8'hE7));
    ix = '0;
    ix = put(ix, 0, 8, 1); ix = put(ix, 1, 8, 64'h8000_0000_0000_0000);
    do_op("R1 R5 R6 vec sew64", 0, 3, 2, 0, '1, 0, 0, pat(8'h42), ix, 0, 0, pat(8'h99));
  endtask

  task automatic t_vec16();
    logic [2*VLEN-1:0] ix;
    ix = '0;
    for (int i = 0; i < 16; i++) ix = put(ix, i, 2, 64'(15 - i));
    ix = put(ix, 3, 2, 16);
    ix = put(ix, 5, 2, 16'h0100);
    do_op("R2 R5 idx16 sew8", 1, 0, 16, 0, '1, 0, 0, pat(8'h5D), ix, 0, 0, pat(8'h21));
    ix = '0;
    ix = put(ix, 0, 2, 1); ix = put(ix, 1, 2, 0); ix = put(ix, 2, 2, 16'hABCD);
    do_op("R2 idx16 sew64", 1, 3, 2, 0, '1, 0, 0, pat(8'h77), ix, 0, 0, pat(8'h08));
  endtask

  task automatic t_scalar();
    do_op("R3 scalar sew16", 2, 1, 8, 0, '1, 0, 0, pat(8'h6A), '0, 5, 0, pat(8'h13));
    do_op("R3 R5 scalar high bits", 2, 1, 8, 0, '1, 0, 0, pat(8'h6A), '0,
          64'h0000_0100_0000_0005, 0, pat(8'h13));
  endtask

  task automatic t_imm();
    do_op("R4 imm sew32", 3, 2, 4, 0, '1, 0, 0, pat(8'h2B), '0, 0, 3, pat(8'hB4));
    do_op("R4 R5 imm equals VLMAX", 3, 2, 4, 0, '1, 0, 0, pat(8'h2B), '0, 0, 4, pat(8'hB4));
    do_op("R4 R6 imm sew8", 3, 0, 16, 0, '1, 0, 0, pat(8'h0F), '0, 0, 11, pat(8'hF0));
  endtask

  task automatic t_body();
    logic [2*VLEN-1:0] ix;
    ix = '0;
    for (int i = 0; i < 16; i++) ix = put(ix, i, 1, 64'(15 - i));
    do_op("R7 vstart 3", 0, 0, 16, 3, '1, 0, 0, pat(8'h1E), ix, 0, 0, pat(8'hD2));
    do_op("R8 mask on", 0, 0, 16, 0, 16'hA5C3, 1, 0, pat(8'h1E), ix, 0, 0, pat(8'hD2));
    do_op("R8 mask ignored", 0, 0, 16, 0, 16'h0000, 0, 0, pat(8'h1E), ix, 0, 0, pat(8'hD2));
    do_op("R9 tail undisturbed", 2, 1, 5, 0, '1, 0, 0, pat(8'h4E), '0, 6, 0, pat(8'h3A));
    do_op("R9 tail agnostic", 2, 1, 5, 0, '1, 0, 1, pat(8'h4E), '0, 6, 0, pat(8'h3A));
  endtask

  task automatic t_stall();
    logic [VLEN-1:0] exp, first;
    int cnt;
    exp = model(3, 1, 8, 0, '1, 0, 0, pat(8'h55), '0, 0, 2, pat(8'hAA));
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_mode = 2'd3; in_sew = 2'd1;
    in_vl = VLW'(8); in_vstart = '0; in_mask = '1; in_mask_en = 1'b0;
    in_tail_agn = 1'b0; in_src = pat(8'h55); in_uimm = 5'd2; in_old = pat(8'hAA);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 0;
    while (!out_valid && cnt < 12) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    first = out_data;
    chk_i("R11 in_ready while stalled", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk_i("R11 out_valid held", int'(out_valid), 1);
    chk_v("R11 data held", out_data, first);
    chk_v("R11 data value", out_data, exp);
    out_ready = 1'b1;
    @(negedge clk);
    chk_i("R11 drained after release", int'(out_valid), 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_vec();
    t_vec16();
    t_scalar();
    t_imm();
    t_body();
    t_stall();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule